// File: doc/BRIEF.md
# BCD Calendar Counter with Two-Stage Prescaler

This block keeps the time of day and the calendar date as packed BCD words. It runs on a single RTC clock. Two cascaded down-counters divide that clock into a one-cycle calendar tick. The first, coarse stage has a 7-bit reload value A. The second, fine stage has a 15-bit reload value S and moves only when the coarse stage wraps. The tick period is therefore (A+1)(S+1) clock cycles, and choosing A and S to suit the clock frequency gives a 1 Hz tick.

A register block elsewhere in the chip drives the reload values, the hour-format select, the freeze input and the load strobes. To set the clock, software raises freeze. It then pulses the time and date load strobes, along with any new reload values, and releases freeze. Counting resumes from the loaded values, and the first tick comes one full period after the release. The date word holds day of month, month, weekday and a two-digit year (years since 2000), with month lengths and leap years handled in hardware.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time word reads 0x000000 and the date word reads 0x002101 (day 01, month 01, weekday 1, year 00).
- R2: Time word layout: seconds BCD in bits [6:0] and minutes BCD in bits [14:8], both counting 00..59. On each tick the seconds advance; 59 wraps to 00 and carries into minutes, and minutes 59 wraps to 00 and carries into hours.
- R3: With fmt_12h_i = 0, hours are BCD in bits [21:16] and count 00..23. 23 wraps to 00 and advances the date by one day.
- R4: With fmt_12h_i = 1, hours count 12, 01 .. 11, and bit 22 is the afternoon flag. Going from 11 to 12 toggles the flag. Going from 11 with the flag set to 12 with the flag clear also advances the date.
- R5: tick_o is high for one cycle every (A+1)(S+1) clock cycles, where A = presc_coarse_i (7 bits) and S = presc_fine_i (15 bits). The calendar advances at the clock edge that ends a tick cycle.
- R6: Date word layout: day BCD in bits [5:0], month BCD in bits [12:8], weekday in bits [15:13] and year BCD in bits [23:16]. After the last day of the month the day goes to 01 and the month advances. April, June, September and November have 30 days; the other months except February have 31.
- R7: February has 29 days when the year value is divisible by 4, otherwise 28.
- R8: The weekday advances with each day carry, counting 1..7 and wrapping from 7 to 1.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R10: While freeze_i is high, tick_o stays low and both words hold unless loaded. time_load_i and date_load_i take effect only while freeze_i is high; at other times they are ignored.
- R11: After freeze_i falls, counting continues from the loaded values, and the first tick arrives (A+1)(S+1) cycles after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_coarse_i | input | 7 | Coarse prescaler reload value A |
| presc_fine_i | input | 15 | Fine prescaler reload value S |
| fmt_12h_i | input | 1 | 0: 24-hour hours, 1: 12-hour hours with afternoon flag |
| freeze_i | input | 1 | Stops prescalers and calendar, enables loads |
| time_load_i | input | 1 | Load strobe for the time word |
| time_load_val_i | input | 23 | Time value to load |
| date_load_i | input | 1 | Load strobe for the date word |
| date_load_val_i | input | 24 | Date value to load |
| time_o | output | 23 | Packed BCD time word |
| date_o | output | 24 | Packed BCD date word |
| tick_o | output | 1 | One-cycle calendar tick |

## Verification
The assertions check four things on every cycle. Time and date hold while frozen or between ticks. No tick occurs during freeze. The seconds units digit steps by exactly one on a tick, and the seconds field stays valid BCD. Only the bench scenarios can show the actual tick period for chosen reload values, the hour carries in both formats, month lengths, leap February, weekday wrap and the year rollover. They also show that a load strobe given while running is ignored; the bench compares all of this against a binary-arithmetic model of the calendar.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int TIME_W = 23;
  localparam int DATE_W = 24;
  localparam logic [DATE_W-1:0] DATE_RST = 24'h002101;

  // two-digit BCD increment, no wrap handling
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'h9) r = {v[7:4] + 4'h1, 4'h0};
    else                r = {v[7:4], v[3:0] + 4'h1};
    return r;
  endfunction

  // last day (BCD) of a BCD month in a BCD year
  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] ybin;
    logic [7:0] r;
    ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      8'h02:                      r = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int A_W = 7,
  parameter int S_W = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] reload_a,
  input  logic [S_W-1:0] reload_s,
  input  logic           freeze,
  output logic           tick
);

  logic [A_W-1:0] a_q, a_d;
  logic [S_W-1:0] s_q, s_d;
  logic           s_en;

  always_comb begin
    s_en = (a_q == '0) && !freeze;
    tick = s_en && (s_q == '0);
    if (freeze)          a_d = reload_a;
    else if (a_q == '0)  a_d = reload_a;
    else                 a_d = a_q - 1'b1;
    if (freeze)          s_d = reload_s;
    else if (s_en)       s_d = (s_q == '0) ? reload_s : s_q - 1'b1;
    else                 s_d = s_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      s_q <= '0;
    end else begin
      a_q <= a_d;
      s_q <= s_d;
    end
  end

endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fmt_12h,
  input  logic              ld_en,
  input  logic [TIME_W-1:0] ld_val,
  output logic [TIME_W-1:0] time_q,
  output logic              day_carry
);

  logic [TIME_W-1:0] t_q, t_d, t_step;
  logic [7:0] sec_inc, min_inc, hr_inc;
  logic sec_wrap, min_wrap, hr_end;
  logic [5:0] hr_next;
  logic pm_next;

  always_comb begin
    sec_inc  = bcd_inc8({1'b0, t_q[6:0]});
    min_inc  = bcd_inc8({1'b0, t_q[14:8]});
    hr_inc   = bcd_inc8({2'b00, t_q[21:16]});
    sec_wrap = (t_q[6:0] == 7'h59);
    min_wrap = (t_q[14:8] == 7'h59);
    hr_next  = hr_inc[5:0];
    pm_next  = t_q[22];
    hr_end   = 1'b0;
    if (!fmt_12h) begin
      if (t_q[21:16] == 6'h23) begin
        hr_next = 6'h00;
        hr_end  = 1'b1;
      end
    end else begin
      if (t_q[21:16] == 6'h12) begin
        hr_next = 6'h01;
      end else if (t_q[21:16] == 6'h11) begin
        hr_next = 6'h12;
        pm_next = ~t_q[22];
        hr_end  = t_q[22];
      end
    end

    t_step = t_q;
    if (sec_wrap) begin
      t_step[6:0] = 7'h00;
      if (min_wrap) begin
        t_step[14:8]  = 7'h00;
        t_step[21:16] = hr_next;
        t_step[22]    = pm_next;
      end else begin
        t_step[14:8] = min_inc[6:0];
      end
    end else begin
      t_step[6:0] = sec_inc[6:0];
    end

    day_carry = sec_wrap && min_wrap && hr_end;

    if (ld_en)      t_d = ld_val;
    else if (tick)  t_d = t_step;
    else            t_d = t_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= '0;
    else        t_q <= t_d;
  end

  assign time_q = t_q;

endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              ld_en,
  input  logic [DATE_W-1:0] ld_val,
  output logic [DATE_W-1:0] date_q
);

  logic [DATE_W-1:0] d_q, d_d, d_step;
  logic [7:0] day_inc, mon_inc, yr_inc, last_day;

  always_comb begin
    day_inc  = bcd_inc8({2'b00, d_q[5:0]});
    mon_inc  = bcd_inc8({3'b000, d_q[12:8]});
    yr_inc   = bcd_inc8(d_q[23:16]);
    last_day = month_last({3'b000, d_q[12:8]}, d_q[23:16]);

    d_step = d_q;
    d_step[15:13] = (d_q[15:13] == 3'd7) ? 3'd1 : d_q[15:13] + 3'd1;
    if ({2'b00, d_q[5:0]} == last_day) begin
      d_step[5:0] = 6'h01;
      if (d_q[12:8] == 5'h12) begin
        d_step[12:8]  = 5'h01;
        d_step[23:16] = (d_q[23:16] == 8'h99) ? 8'h00 : yr_inc;
      end else begin
        d_step[12:8] = mon_inc[4:0];
      end
    end else begin
      d_step[5:0] = day_inc[5:0];
    end

    if (ld_en)     d_d = ld_val;
    else if (adv)  d_d = d_step;
    else           d_d = d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= DATE_RST;
    else        d_q <= d_d;
  end

  assign date_q = d_q;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int A_W = 7,
  parameter int S_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [A_W-1:0]    presc_coarse_i,
  input  logic [S_W-1:0]    presc_fine_i,
  input  logic              fmt_12h_i,
  input  logic              freeze_i,
  input  logic              time_load_i,
  input  logic [TIME_W-1:0] time_load_val_i,
  input  logic              date_load_i,
  input  logic [DATE_W-1:0] date_load_val_i,
  output logic [TIME_W-1:0] time_o,
  output logic [DATE_W-1:0] date_o,
  output logic              tick_o
);

  logic tick;
  logic day_carry;
  logic t_ld, d_ld;

  assign t_ld = time_load_i && freeze_i;
  assign d_ld = date_load_i && freeze_i;

  rtc_prescaler #(.A_W(A_W), .S_W(S_W)) i_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_a (presc_coarse_i),
    .reload_s (presc_fine_i),
    .freeze   (freeze_i),
    .tick     (tick)
  );

  rtc_time_cnt i_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .fmt_12h   (fmt_12h_i),
    .ld_en     (t_ld),
    .ld_val    (time_load_val_i),
    .time_q    (time_o),
    .day_carry (day_carry)
  );

  rtc_date_cnt i_date (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (tick && day_carry),
    .ld_en  (d_ld),
    .ld_val (date_load_val_i),
    .date_q (date_o)
  );

  assign tick_o = tick;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        freeze_i,
  input logic        time_load_i,
  input logic        date_load_i,
  input logic [22:0] time_o,
  input logic [23:0] date_o,
  input logic        tick_o
);

  p_no_tick_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |-> !tick_o);

  p_time_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_o && !(freeze_i && time_load_i)) |=> $stable(time_o));

  p_date_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_o && !(freeze_i && date_load_i)) |=> $stable(date_o));

  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && time_o[3:0] != 4'h9) |=> (time_o[3:0] == $past(time_o[3:0]) + 4'h1));

  p_sec_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (time_o[3:0] <= 4'h9) && (time_o[6:4] <= 3'h5));

endmodule

bind rtc_calendar rtc_calendar_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .freeze_i    (freeze_i),
  .time_load_i (time_load_i),
  .date_load_i (date_load_i),
  .time_o      (time_o),
  .date_o      (date_o),
  .tick_o      (tick_o)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [6:0]  pa;
  logic [14:0] ps;
  logic fmt, frz, tld, dld;
  logic [22:0] tv;
  logic [23:0] dv;
  logic [22:0] time_o;
  logic [23:0] date_o;
  logic tick_o;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar i_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .presc_coarse_i(pa), .presc_fine_i(ps),
    .fmt_12h_i(fmt), .freeze_i(frz), .time_load_i(tld), .time_load_val_i(tv),
    .date_load_i(dld), .date_load_val_i(dv), .time_o(time_o), .date_o(date_o),
    .tick_o(tick_o));

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [46:0] model_step(input logic [22:0] t, input logic [23:0] d, input logic f);
    int sec, mn, hr, day, mon, yr, wd;
    logic pm, carry;
    logic [7:0] bs, bm, bh, bd, bo, by;
    sec = b2i({1'b0, t[6:0]}); mn = b2i({1'b0, t[14:8]}); hr = b2i({2'b0, t[21:16]});
    pm = t[22];
    day = b2i({2'b0, d[5:0]}); mon = b2i({3'b0, d[12:8]}); yr = b2i(d[23:16]);
    wd = int'(d[15:13]);
    carry = 1'b0;
    sec++;
    if (sec == 60) begin
      sec = 0; mn++;
      if (mn == 60) begin
        mn = 0;
        if (!f) begin
          hr++;
          if (hr == 24) begin hr = 0; carry = 1'b1; end
        end else if (hr == 11) begin
          hr = 12;
          if (pm) begin pm = 1'b0; carry = 1'b1; end else pm = 1'b1;
        end else if (hr == 12) hr = 1;
        else hr++;
      end
    end
    if (carry) begin
      wd = (wd == 7) ? 1 : wd + 1;
      if (day == days_in(mon, yr)) begin
        day = 1; mon++;
        if (mon == 13) begin mon = 1; yr = (yr + 1) % 100; end
      end else day++;
    end
    bs = i2b(sec); bm = i2b(mn); bh = i2b(hr);
    bd = i2b(day); bo = i2b(mon); by = i2b(yr);
    return {pm, bh[5:0], 1'b0, bm[6:0], 1'b0, bs[6:0],
            by, 3'(wd), bo[4:0], 2'b00, bd[5:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_state(input logic [22:0] t, input logic [23:0] d, input logic f);
    @(posedge clk); #1;
    frz = 1'b1; fmt = f; pa = '0; ps = '0;
    tld = 1'b1; dld = 1'b1; tv = t; dv = d;
    @(posedge clk); #1;
    tld = 1'b0; dld = 1'b0;
  endtask

  task automatic expect_after(input string tag, input logic [22:0] t, input logic [23:0] d,
                              input logic f, input int n);
    logic [46:0] m;
    m = {t, d};
    for (int i = 0; i < n; i++) m = model_step(m[46:24], m[23:0], f);
    set_state(t, d, f);
    frz = 1'b0;
    repeat (n) @(posedge clk);
    #1 frz = 1'b1;
    @(negedge clk);
    chk({tag, " time"}, 32'(time_o), 32'(m[46:24]));
    chk({tag, " date"}, 32'(date_o), 32'(m[23:0]));
  endtask

  task automatic period_test(input logic [6:0] a, input logic [14:0] s);
    int cnt;
    int exp_n;
    logic [46:0] m;
    exp_n = (int'(a) + 1) * (int'(s) + 1);
    set_state(23'h123456 & 23'h3F7F7F, 24'h24_2315, 1'b0);
    m = model_step(23'h123456 & 23'h3F7F7F, 24'h242315, 1'b0);
    m = model_step(m[46:24], m[23:0], 1'b0);
    pa = a; ps = s;
    @(posedge clk); #1;
    frz = 1'b0;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!tick_o && cnt < 70000);
    chk("R11 first tick delay", 32'(cnt), 32'(exp_n));
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!tick_o && cnt < 70000);
    chk("R5 tick period", 32'(cnt), 32'(exp_n));
    @(posedge clk); #1 frz = 1'b1;
    @(negedge clk);
    chk("R11 resume from loaded time", 32'(time_o), 32'(m[46:24]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog R5 R10: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; frz = 1'b1; fmt = 1'b0; pa = '0; ps = '0;
    tld = 1'b0; dld = 1'b0; tv = '0; dv = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset time", 32'(time_o), 32'h0);
    chk("R1 reset date", 32'(date_o), 32'h002101);

    expect_after("R2 second/minute carry", 23'h00_0058, 24'h00_2101, 1'b0, 3);
    expect_after("R2 minute wrap", 23'h05_5959, 24'h00_2101, 1'b0, 1);
    expect_after("R3 midnight rollover", 23'h23_5959, 24'h15_4310, 1'b0, 1);
    expect_after("R4 noon flag set", 23'h11_5959, 24'h15_4310, 1'b1, 1);
    expect_after("R4 12 to 01", 23'h52_5959, 24'h15_4310, 1'b1, 1);
    expect_after("R4 midnight day carry", 23'h51_5959, 24'h15_4310, 1'b1, 1);
    expect_after("R6 april end", 23'h23_5959, 24'h21_4430, 1'b0, 1);
    expect_after("R6 january end", 23'h23_5959, 24'h21_2131, 1'b0, 1);
    expect_after("R7 leap feb 28", 23'h23_5959, 24'h24_2228, 1'b0, 1);
    expect_after("R7 common feb 28", 23'h23_5959, 24'h23_2228, 1'b0, 1);
    expect_after("R7 leap feb 29", 23'h23_5959, 24'h00_2229, 1'b0, 1);
    expect_after("R8 weekday wrap", 23'h23_5959, 24'h10_E305, 1'b0, 1);
    expect_after("R9 year rollover", 23'h23_5959, 24'h99_F231, 1'b0, 1);

    // R10: freeze holds
    set_state(23'h10_2030, 24'h05_6615, 1'b0);
    repeat (20) begin
      @(negedge clk);
      chk("R10 no tick while frozen", 32'(tick_o), 32'h0);
    end
    chk("R10 time held frozen", 32'(time_o), 32'h102030);
    // R10: load ignored when running
    pa = 7'd127; ps = 15'd32767;
    @(posedge clk); #1 frz = 1'b0;
    tld = 1'b1; dld = 1'b1; tv = 23'h01_0101; dv = 24'h01_2101;
    @(posedge clk); #1 tld = 1'b0; dld = 1'b0;
    @(negedge clk);
    chk("R10 time load ignored", 32'(time_o), 32'h102030);
    chk("R10 date load ignored", 32'(date_o), 32'h056615);
    @(posedge clk); #1 frz = 1'b1;

    period_test(7'd0, 15'd0);
    period_test(7'd3, 15'd4);
    period_test(7'd127, 15'd3);
    period_test(7'd0, 15'd1000);
    for (int i = 0; i < 4; i++)
      period_test(7'($urandom % 8), 15'($urandom % 40));

    for (int i = 0; i < 16; i++) begin
      logic f;
      int hr, mo, yr, dy, n;
      logic pmf;
      logic [7:0] bh, bs, bd, bo, by;
      f = 1'($urandom % 2);
      pmf = 1'($urandom % 2);
      hr = f ? 11 : 23;
      mo = 1 + int'($urandom % 12);
      yr = int'($urandom % 100);
      dy = days_in(mo, yr) - int'($urandom % 2);
      n = 1 + int'($urandom % 150);
      bh = i2b(hr); bs = i2b(int'($urandom % 60));
      bd = i2b(dy); bo = i2b(mo); by = i2b(yr);
      expect_after("R3_R4_R6_R9 random",
                   {f & pmf, bh[5:0], 1'b0, 7'h59, 1'b0, bs[6:0]},
                   {by, 3'(1 + ($urandom % 7)), bo[4:0], 2'b00, bd[5:0]}, f, n);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule